// File: doc/BRIEF.md
# Receive Descriptor Chain Controller

This block moves received frames into host memory. Memory holds a linked list of buffer descriptors. Software points the controller at the first descriptor and writes an enable command. The controller then fetches each descriptor over a single-word request/acknowledge memory port. It fills the descriptor's buffer with bytes taken from a small byte FIFO, which the link-side stream feeds. It writes a completion status back and follows the link to the next descriptor.

The chain ends in one of two ways:
- A descriptor the host has not handed back (ownership already set) stops the walk with an idle interrupt.
- A zero link stops the walk with an idle interrupt and also sets a sticky chain-done flag. Writing the descriptor pointer clears that flag.

A disable command always beats an enable in the same write. A disable takes effect only at the next descriptor boundary. A receive-reset command returns the block to a clean idle state.

Each descriptor is three 32-bit words at the descriptor address:
- +0: link to the next descriptor.
- +4: buffer address.
- +8: command/status word. Bit 31 is ownership, bit 30 is overflow, bit 29 is interrupt request, and bits 15:0 are the buffer length on fetch and the stored byte count on write-back.

Top module: `rx_chain_ctrl`

## Requirements
- R1: A command write with the disable bit set clears the enable state, even when the enable bit is also set in that write, and starts no descriptor fetch.
- R2: A command write with enable set (disable and reset clear) while the controller is idle raises a read request in the next cycle at the current descriptor-pointer address.
- R3: A frame whose first byte arrives while the enable state is clear is accepted with ready held high and dropped in full. It causes no memory traffic and leaves no byte in the FIFO.
- R4: A write to the descriptor-pointer register clears the chain-done flag.
- R5: If the fetched command/status word has bit 31 set, the controller pulses irq_idle_o and returns to idle. It writes nothing to memory and does not set chain-done.
- R6: After the status write-back of a descriptor whose bit 29 is set, irq_desc_o pulses for one cycle. No pulse follows when bit 29 is clear.
- R7: If the enable state is clear when a status write-back is acknowledged, the controller goes idle and fetches no further descriptor.
- R8: After a write-back with enable still set, a zero link pulses irq_idle_o, sets chain-done and enters idle. A non-zero link becomes the descriptor pointer, and that descriptor is read next.
- R9: A command write with the reset bit set clears the enable state and chain-done, empties the FIFO, and forces the controller to idle.
- R10: The write-back to descriptor+8 keeps bits 29:16 of the fetched word, sets bit 31, and puts the stored byte count in bits 15:0.
- R11: Frame bytes beyond the buffer length are discarded. The stored count equals the buffer length, and bit 30 of the write-back is set.
- R12: A memory request keeps its address, direction and write data unchanged until acknowledged.
- R13: Stored bytes go little-endian into 32-bit words at buffer+4k. Lanes after the last stored byte of a frame are written as zero, and no word beyond the stored bytes is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_wr_i | input | 1 | Command register write strobe |
| cmd_en_i | input | 1 | Command enable bit |
| cmd_dis_i | input | 1 | Command disable bit |
| cmd_rst_i | input | 1 | Command receive-reset bit |
| dp_wr_i | input | 1 | Descriptor-pointer write strobe |
| dp_wdata_i | input | AW | Descriptor-pointer write value |
| rx_valid_i | input | 1 | Link byte valid |
| rx_data_i | input | 8 | Link byte |
| rx_last_i | input | 1 | Last byte of frame |
| rx_ready_o | output | 1 | Link byte accepted |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge, completes the transfer |
| mem_rdata_i | input | 32 | Memory read data, valid with acknowledge |
| irq_idle_o | output | 1 | Receive-idle interrupt pulse |
| irq_desc_o | output | 1 | Per-descriptor interrupt pulse |
| chain_done_o | output | 1 | Sticky chain-done flag |
| enabled_o | output | 1 | Current enable state |
| busy_o | output | 1 | Controller not idle |

## Verification
The assertions assume that software does not write the descriptor pointer while the controller is walking a chain. The request-stability property depends on this, because a read address is derived from that pointer. They also assume that the memory side acknowledges only while a request is raised. The bench writes the pointer only while busy_o is low, and its memory responder acknowledges only an active request, after a random delay. It issues a receive reset only while the controller sits idle. This way no transfer is cut off in a way that would break the request-hold rule.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DRD, ST_CHECK, ST_FILL, ST_WDATA, ST_WCS, ST_ADV
  } rxc_state_e;

  localparam int CS_OWN  = 31;
  localparam int CS_OVF  = 30;
  localparam int CS_IRQ  = 29;
  localparam int LEN_W   = 16;
  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
endpackage

// File: rtl/rxc_fifo.sv
module rxc_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = store_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) store_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  p_fifo_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_flush_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/rxc_regs.sv
module rxc_regs #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_wr_i,
  input  logic          cmd_en_i,
  input  logic          cmd_dis_i,
  input  logic          cmd_rst_i,
  input  logic          dp_wr_i,
  input  logic [AW-1:0] dp_wdata_i,
  input  logic          dp_load_i,
  input  logic [AW-1:0] dp_next_i,
  input  logic          set_done_i,
  output logic          enable_o,
  output logic          done_o,
  output logic [AW-1:0] dp_o,
  output logic          kick_o,
  output logic          flush_o
);
  logic          enable_q, done_q;
  logic [AW-1:0] dp_q;

  assign flush_o  = cmd_wr_i && cmd_rst_i;
  assign kick_o   = cmd_wr_i && cmd_en_i && !cmd_dis_i && !cmd_rst_i;
  assign enable_o = enable_q;
  assign done_o   = done_q;
  assign dp_o     = dp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= 1'b0;
      done_q   <= 1'b0;
      dp_q     <= '0;
    end else begin
      if (cmd_wr_i) begin
        if (cmd_rst_i || cmd_dis_i) enable_q <= 1'b0;
        else if (cmd_en_i)          enable_q <= 1'b1;
      end
      if (dp_wr_i || flush_o) done_q <= 1'b0;
      else if (set_done_i)    done_q <= 1'b1;
      if (dp_load_i)    dp_q <= dp_next_i;
      else if (dp_wr_i) dp_q <= dp_wdata_i;
    end
  end

  p_dis_wins_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && cmd_dis_i |=> !enable_q);
  p_dp_clears_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dp_wr_i |=> !done_q);
  p_reset_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !enable_q && !done_q);
endmodule

// File: rtl/rxc_walker.sv
module rxc_walker
  import rxc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              kick_i,
  input  logic              enable_i,
  input  logic [AW-1:0]     dp_i,
  input  logic              fifo_empty_i,
  input  logic [BYTE_W:0]   fifo_dout_i,
  output logic              fifo_pop_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              dp_load_o,
  output logic [AW-1:0]     dp_next_o,
  output logic              set_done_o,
  output logic              irq_idle_o,
  output logic              irq_desc_o,
  output logic              busy_o
);
  rxc_state_e        state_q;
  logic [1:0]        widx_q;
  logic [AW-1:0]     link_q, buf_q, wofs_q;
  logic [WORD_W-1:0] cs_q, word_q;
  logic [LEN_W-1:0]  cnt_q;
  logic              pend_q, last_q, ovf_q, irq_idle_q, irq_desc_q;

  logic [BYTE_W-1:0] in_byte;
  logic              in_last, room;

  assign in_byte = fifo_dout_i[BYTE_W-1:0];
  assign in_last = fifo_dout_i[BYTE_W];
  assign room    = cnt_q < cs_q[LEN_W-1:0];

  assign fifo_pop_o = (state_q == ST_FILL) && !fifo_empty_i;
  assign mem_req_o  = (state_q == ST_DRD) || (state_q == ST_WDATA) || (state_q == ST_WCS);
  assign mem_we_o   = (state_q == ST_WDATA) || (state_q == ST_WCS);
  assign busy_o     = (state_q != ST_IDLE);
  assign irq_idle_o = irq_idle_q;
  assign irq_desc_o = irq_desc_q;
  assign dp_load_o  = (state_q == ST_ADV) && (link_q != '0);
  assign dp_next_o  = link_q;
  assign set_done_o = (state_q == ST_ADV) && (link_q == '0);

  always_comb begin
    mem_addr_o  = dp_i + AW'({widx_q, 2'b00});
    mem_wdata_o = '0;
    unique case (state_q)
      ST_WDATA: begin
        mem_addr_o  = buf_q + wofs_q;
        mem_wdata_o = word_q;
      end
      ST_WCS: begin
        mem_addr_o  = dp_i + AW'(8);
        mem_wdata_o = {1'b1, ovf_q, cs_q[CS_IRQ:LEN_W], cnt_q};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      widx_q     <= '0;
      link_q     <= '0;
      buf_q      <= '0;
      cs_q       <= '0;
      word_q     <= '0;
      wofs_q     <= '0;
      cnt_q      <= '0;
      pend_q     <= 1'b0;
      last_q     <= 1'b0;
      ovf_q      <= 1'b0;
      irq_idle_q <= 1'b0;
      irq_desc_q <= 1'b0;
    end else if (flush_i) begin
      state_q    <= ST_IDLE;
      widx_q     <= '0;
      irq_idle_q <= 1'b0;
      irq_desc_q <= 1'b0;
    end else begin
      irq_idle_q <= 1'b0;
      irq_desc_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (kick_i) begin
          state_q <= ST_DRD;
          widx_q  <= '0;
        end
        ST_DRD: if (mem_ack_i) begin
          unique case (widx_q)
            2'd0:    link_q <= AW'(mem_rdata_i);
            2'd1:    buf_q  <= AW'(mem_rdata_i);
            default: cs_q   <= mem_rdata_i;
          endcase
          if (widx_q == 2'd2) begin
            state_q <= ST_CHECK;
            widx_q  <= '0;
          end else begin
            widx_q <= widx_q + 1'b1;
          end
        end
        ST_CHECK: begin
          if (cs_q[CS_OWN]) begin
            irq_idle_q <= 1'b1;
            state_q    <= ST_IDLE;
          end else begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
            wofs_q  <= '0;
            word_q  <= '0;
            pend_q  <= 1'b0;
            last_q  <= 1'b0;
            ovf_q   <= 1'b0;
          end
        end
        ST_FILL: if (!fifo_empty_i) begin
          last_q <= in_last;
          if (room) begin
            word_q[{cnt_q[1:0], 3'b000} +: BYTE_W] <= in_byte;
            cnt_q  <= cnt_q + 1'b1;
            pend_q <= 1'b1;
            if (cnt_q[1:0] == 2'd3 || in_last) state_q <= ST_WDATA;
          end else begin
            ovf_q <= 1'b1;
            if (in_last) state_q <= pend_q ? ST_WDATA : ST_WCS;
          end
        end
        ST_WDATA: if (mem_ack_i) begin
          word_q  <= '0;
          pend_q  <= 1'b0;
          wofs_q  <= wofs_q + AW'(4);
          state_q <= last_q ? ST_WCS : ST_FILL;
        end
        ST_WCS: if (mem_ack_i) begin
          irq_desc_q <= cs_q[CS_IRQ];
          state_q    <= enable_i ? ST_ADV : ST_IDLE;
        end
        ST_ADV: begin
          if (link_q == '0) begin
            irq_idle_q <= 1'b1;
            state_q    <= ST_IDLE;
          end else begin
            state_q <= ST_DRD;
            widx_q  <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_req_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni || flush_i)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
      && $stable(mem_wdata_o));
  p_owned_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || flush_i)
    state_q == ST_CHECK && cs_q[CS_OWN] |=> state_q == ST_IDLE && irq_idle_o && !mem_req_o);
  p_count_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FILL |-> cnt_q <= cs_q[LEN_W-1:0]);
  p_halt_boundary_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || flush_i)
    state_q == ST_WCS && mem_ack_i && !enable_i |=> state_q == ST_IDLE);
  p_flush_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> state_q == ST_IDLE);
  p_irq_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_idle_o && irq_desc_o));
endmodule

// File: rtl/rx_chain_ctrl.sv
module rx_chain_ctrl
  import rxc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int FIFO_DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_wr_i,
  input  logic          cmd_en_i,
  input  logic          cmd_dis_i,
  input  logic          cmd_rst_i,
  input  logic          dp_wr_i,
  input  logic [AW-1:0] dp_wdata_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_last_i,
  output logic          rx_ready_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          irq_idle_o,
  output logic          irq_desc_o,
  output logic          chain_done_o,
  output logic          enabled_o,
  output logic          busy_o
);
  localparam int FW = BYTE_W + 1;

  logic          enable, flush, kick, dp_load, set_done;
  logic [AW-1:0] dp, dp_next;
  logic          f_empty, f_full, f_pop, f_push;
  logic [FW-1:0] f_dout;
  logic          in_frame_q, keep_q, keep_now;

  // accept/drop decision is taken on the first byte of each frame
  assign keep_now   = in_frame_q ? keep_q : enable;
  assign rx_ready_o = keep_now ? !f_full : 1'b1;
  assign f_push     = rx_valid_i && rx_ready_o && keep_now;
  assign enabled_o  = enable;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      keep_q     <= 1'b0;
    end else begin
      if (rx_valid_i && rx_ready_o) begin
        in_frame_q <= !rx_last_i;
        if (!in_frame_q) keep_q <= enable;
      end
      if (flush) keep_q <= 1'b0;
    end
  end

  rxc_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni, .cmd_wr_i, .cmd_en_i, .cmd_dis_i, .cmd_rst_i,
    .dp_wr_i, .dp_wdata_i,
    .dp_load_i(dp_load), .dp_next_i(dp_next), .set_done_i(set_done),
    .enable_o(enable), .done_o(chain_done_o), .dp_o(dp),
    .kick_o(kick), .flush_o(flush)
  );

  rxc_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .flush_i(flush),
    .push_i(f_push), .din_i({rx_last_i, rx_data_i}),
    .pop_i(f_pop), .dout_o(f_dout), .empty_o(f_empty), .full_o(f_full)
  );

  rxc_walker #(.AW(AW)) u_walk (
    .clk_i, .rst_ni, .flush_i(flush), .kick_i(kick), .enable_i(enable), .dp_i(dp),
    .fifo_empty_i(f_empty), .fifo_dout_i(f_dout), .fifo_pop_o(f_pop),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
    .dp_load_o(dp_load), .dp_next_o(dp_next), .set_done_o(set_done),
    .irq_idle_o, .irq_desc_o, .busy_o
  );

  p_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !keep_now |-> rx_ready_o && !f_push);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
endmodule

// File: tb/rx_chain_ctrl_test.sv
module rx_chain_ctrl_test;
  localparam int AW = 32;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cmd_wr_i = 0, cmd_en_i = 0, cmd_dis_i = 0, cmd_rst_i = 0;
  logic dp_wr_i = 0;
  logic [AW-1:0] dp_wdata_i = '0;
  logic rx_valid_i = 0, rx_last_i = 0;
  logic [7:0] rx_data_i = '0;
  logic rx_ready_o, mem_req_o, mem_we_o, mem_ack_i = 0;
  logic [AW-1:0] mem_addr_o;
  logic [31:0] mem_wdata_o, mem_rdata_i = '0;
  logic irq_idle_o, irq_desc_o, chain_done_o, enabled_o, busy_o;

  int total = 0, bad = 0;
  int n_idle = 0, n_desc = 0, n_req = 0, n_wr = 0, proto_err = 0, stalls = 0;
  logic [31:0] mem [0:255];
  logic [7:0]  fb [0:63];
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;

  always #4 clk_i = ~clk_i;

  rx_chain_ctrl #(.AW(AW), .FIFO_DEPTH(8)) uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder with random acknowledge delay
  initial begin
    logic pend = 0, hwe = 0;
    logic [31:0] ha = '0;
    forever begin
      @(negedge clk_i);
      if (pend && (!mem_req_o || mem_addr_o != ha || mem_we_o != hwe)) proto_err++;
      if (irq_idle_o) n_idle++;
      if (irq_desc_o) n_desc++;
      if (mem_req_o) n_req++;
      if (mem_req_o && $urandom_range(0, 2) != 0) begin
        mem_ack_i = 1;
        if (mem_we_o) begin mem[mem_addr_o[9:2]] = mem_wdata_o; n_wr++; end
        else mem_rdata_i = mem[mem_addr_o[9:2]];
        pend = 0;
      end else begin
        mem_ack_i = 0;
        pend = mem_req_o; ha = mem_addr_o; hwe = mem_we_o;
      end
    end
  end

  task automatic cmd(logic en, logic dis, logic rst);
    @(negedge clk_i);
    cmd_wr_i = 1; cmd_en_i = en; cmd_dis_i = dis; cmd_rst_i = rst;
    @(negedge clk_i);
    cmd_wr_i = 0; cmd_en_i = 0; cmd_dis_i = 0; cmd_rst_i = 0;
  endtask

  task automatic set_dp(logic [31:0] v);
    @(negedge clk_i);
    dp_wr_i = 1; dp_wdata_i = v;
    @(negedge clk_i);
    dp_wr_i = 0;
  endtask

  task automatic desc(int a, logic [31:0] link, logic [31:0] bp, logic [31:0] cs);
    mem[a/4] = link; mem[a/4+1] = bp; mem[a/4+2] = cs;
  endtask

  task automatic fill_sent();
    for (int i = 32; i < 64; i++) mem[i] = SENT;
  endtask

  task automatic make_frame(int n);
    for (int i = 0; i < n; i++) fb[i] = 8'($urandom);
  endtask

  // send fb[0..n-1]; optional disable command issued at byte dis_at
  task automatic send(int n, int dis_at);
    @(negedge clk_i);
    for (int i = 0; i < n; i++) begin
      rx_valid_i = 1; rx_data_i = fb[i]; rx_last_i = (i == n - 1);
      if (i == dis_at) begin cmd_wr_i = 1; cmd_dis_i = 1; end
      while (!rx_ready_o) begin stalls++; @(negedge clk_i); end
      @(negedge clk_i);
      cmd_wr_i = 0; cmd_dis_i = 0;
      if ($urandom_range(0, 3) == 0) begin rx_valid_i = 0; @(negedge clk_i); end
    end
    rx_valid_i = 0; rx_last_i = 0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
  endtask

  function automatic logic [31:0] exp_word(int k, int n);
    logic [31:0] w = '0;
    for (int l = 0; l < 4; l++) if (4 * k + l < n) w[8*l +: 8] = fb[4*k+l];
    return w;
  endfunction

  initial begin
    #1600000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int i0, d0, r0, w0;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check("reset busy", busy_o, 0);
    check("reset mem_req", mem_req_o, 0);
    check("reset chain_done", chain_done_o, 0);
    check("reset enabled", enabled_o, 0);

    // R1: disable beats enable
    cmd(1, 1, 0);
    @(negedge clk_i);
    check("R1 enabled after en+dis", enabled_o, 0);
    check("R1 busy after en+dis", busy_o, 0);

    // R3: frame dropped while disabled
    r0 = n_req; stalls = 0;
    make_frame(6); send(6, -1);
    repeat (4) @(negedge clk_i);
    check("R3 no stall while disabled", stalls, 0);
    check("R3 no memory traffic", n_req - r0, 0);

    // R2/R8/R10/R11/R13/R6: two-descriptor chain
    fill_sent();
    desc(32'h00, 32'h0C, 32'h80, 32'h2000_0010);
    desc(32'h0C, 32'h00, 32'hC0, 32'h0000_0008);
    set_dp(0);
    i0 = n_idle; d0 = n_desc;
    cmd(1, 0, 0);
    check("R2 fetch request", mem_req_o, 1);
    check("R2 fetch is read", mem_we_o, 0);
    check("R2 fetch address", mem_addr_o, 0);
    make_frame(10); send(10, -1);
    repeat (20) @(negedge clk_i);
    check("R10 first status", mem[2], 32'hA000_000A);
    check("R13 word0", mem[32], exp_word(0, 10));
    check("R13 word1", mem[33], exp_word(1, 10));
    check("R13 word2 zero lanes", mem[34], exp_word(2, 10));
    check("R13 no extra word", mem[35], SENT);
    make_frame(12); send(12, -1);
    wait_idle();
    check("R11 truncated status", mem[5], 32'hC000_0008);
    check("R11 word0", mem[48], exp_word(0, 8));
    check("R11 word1", mem[49], exp_word(1, 8));
    check("R11 discarded bytes", mem[50], SENT);
    check("R6 one desc irq", n_desc - d0, 1);
    check("R8 idle irq at null link", n_idle - i0, 1);
    check("R8 chain done", chain_done_o, 1);

    // R9: bytes parked in FIFO, then receive reset
    make_frame(3); send(3, -1);
    repeat (3) @(negedge clk_i);
    cmd(0, 0, 1);
    @(negedge clk_i);
    check("R9 enable cleared", enabled_o, 0);
    check("R9 chain done cleared", chain_done_o, 0);
    check("R9 idle", busy_o, 0);
    fill_sent();
    desc(32'h00, 32'h00, 32'h80, 32'h0000_0010);
    set_dp(0);
    cmd(1, 0, 0);
    make_frame(5); send(5, -1);
    wait_idle();
    check("R9 fifo emptied count", mem[2], 32'h8000_0005);
    check("R9 fifo emptied data", mem[32], exp_word(0, 5));

    // R4: pointer write clears chain done
    check("R4 done before write", chain_done_o, 1);
    set_dp(32'h30);
    check("R4 done cleared", chain_done_o, 0);

    // R5: owned descriptor
    desc(32'h30, 32'h00, 32'h80, 32'h8000_0010);
    i0 = n_idle; w0 = n_wr;
    cmd(1, 0, 0);
    repeat (12) @(negedge clk_i);
    check("R5 idle irq", n_idle - i0, 1);
    check("R5 no writes", n_wr - w0, 0);
    check("R5 status untouched", mem[14], 32'h8000_0010);
    check("R5 no chain done", chain_done_o, 0);
    check("R5 idle", busy_o, 0);

    // R7: disable mid-frame halts at boundary
    fill_sent();
    desc(32'h00, 32'h0C, 32'h80, 32'h0000_0010);
    desc(32'h0C, 32'h00, 32'hC0, 32'h0000_0008);
    set_dp(0);
    i0 = n_idle; r0 = n_req;
    cmd(1, 0, 0);
    make_frame(10); send(10, 4);
    wait_idle();
    repeat (6) @(negedge clk_i);
    check("R7 current desc completed", mem[2], 32'h8000_000A);
    check("R7 next desc untouched", mem[5], 32'h0000_0008);
    check("R7 enable clear", enabled_o, 0);
    check("R7 no idle irq", n_idle - i0, 0);
    check("R7 no chain done", chain_done_o, 0);

    // random single-descriptor frames
    for (int it = 0; it < 24; it++) begin
      int bl, fl, st;
      logic irq;
      bl = $urandom_range(0, 16); fl = $urandom_range(1, 24); irq = 1'($urandom);
      st = (fl < bl) ? fl : bl;
      fill_sent();
      desc(32'h00, 32'h00, 32'h80, {2'b00, irq, 13'd0, 16'(bl)});
      set_dp(0);
      i0 = n_idle; d0 = n_desc;
      cmd(1, 0, 0);
      make_frame(fl); send(fl, -1);
      wait_idle();
      check("R10 R11 random status", mem[2],
            {1'b1, (fl > bl), irq, 13'd0, 16'(st)});
      for (int k = 0; k < 5; k++)
        check("R13 random word", mem[32+k], (4 * k < st) ? exp_word(k, st) : SENT);
      check("R6 random desc irq", n_desc - d0, 32'(irq));
      check("R8 random idle irq", n_idle - i0, 1);
    end

    check("R12 request held until ack", proto_err, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule